// File: doc/BRIEF.md
# Multiplexed Seven-Segment Display Controller

This block sits between a processor's data bus and an eight-digit LED display whose digits share one set of segment lines. The processor writes one byte per digit through a write strobe with a digit address. In numeric mode, the low nibble of the byte is a BCD digit. It is turned into a seven-segment pattern before it is stored. In raw mode, the byte already holds segment bits, for example to spell out a text message, and is stored exactly as written. The processor normally sends the primary quantity's digits first and the secondary quantity's digits after them, but any address order is accepted.

A free-running scan steps through the digits in a fixed cycle. For each digit it lights one digit enable and puts that digit's stored pattern on the segment lines. One scan index addresses both the storage read port and the digit-enable decoder, so a pattern can never appear under the wrong digit. The segment lines are held dark for the first clock of every digit slot, so the previous digit's pattern does not ghost onto the new one.

Top module: `segscan_ctrl`

## Requirements
- R1: While reset is held, `dig_en` is 8'b0000_0001 and `seg_out` is zero. Every stored entry is cleared, so after reset each digit shows zero segments until it is written.
- R2: When `raw_mode` is low, a write with `wr_data[3:0]` between 0 and 9 stores the seven-segment image of that digit, with a in bit 0 through g in bit 6. For example, 0 becomes 0x3F and 1 becomes 0x06. Bit 7 (decimal point) is copied from `wr_data[7]`, and bits 6:4 of the bus are ignored.
- R3: When `raw_mode` is low, codes 10 to 15 in `wr_data[3:0]` store a pattern with bits 6:0 all zero. Bit 7 is still taken from `wr_data[7]`.
- R4: When `raw_mode` is high, a write stores all eight bits of `wr_data` unchanged as the segment pattern.
- R5: Exactly one bit of `dig_en` is high at any time. Each digit stays lit for SCAN_DIV clocks, and then the lit bit moves from index k to k+1, wrapping from 7 back to 0.
- R6: `seg_out` is zero during the first clock of every digit slot, including the first slot after reset.
- R7: A write changes only the entry at `wr_addr`. If that digit is lit and not in its blank clock, the new pattern shows on `seg_out` from the next clock. Writes never change the scan timing or the digit order.
- R8: Outside the blank clock, `seg_out` equals the stored entry of the digit whose `dig_en` bit is high, and it holds steady for the rest of the slot unless that entry is rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the scan and the writes advance on its rising edge |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe for one clock |
| wr_addr | input | 3 | Digit index of the entry to write |
| wr_data | input | 8 | Bus byte: a BCD nibble plus a decimal point, or a raw segment pattern |
| raw_mode | input | 1 | 1 = store the byte unchanged, 0 = decode it as BCD |
| seg_out | output | 8 | Active-high segments a..g in bits 0..6, decimal point in bit 7 |
| dig_en | output | 8 | Active-high one-hot digit enable |

## Verification
The assertions assume that `raw_mode` and `wr_data` are steady and valid whenever `wr_en` is high. They also assume that `wr_addr` is always below the digit count, which holds for eight digits and a three-bit address. The blank and hold properties further assume that SCAN_DIV is at least two, so every slot has one dark clock and at least one lit clock. The bench drives every input on the falling edge, so nothing changes near the capturing edge. It keeps the bench's SCAN_DIV at four and only ever issues in-range addresses, including bursts of back-to-back writes across all digits while the scan is running.

// File: rtl/segscan_pkg.sv
package segscan_pkg;

  localparam int SEG_W = 8;

  typedef logic [SEG_W-1:0] seg_t;

  // BCD nibble to segment image: a = bit0 ... g = bit6, dp = bit7.
  // Codes above nine leave every stroke dark.
  function automatic seg_t bcd_to_seg(input logic [3:0] code, input logic dp);
    seg_t img;
    case (code)
      4'd0:    img = 8'h3F;
      4'd1:    img = 8'h06;
      4'd2:    img = 8'h5B;
      4'd3:    img = 8'h4F;
      4'd4:    img = 8'h66;
      4'd5:    img = 8'h6D;
      4'd6:    img = 8'h7D;
      4'd7:    img = 8'h07;
      4'd8:    img = 8'h7F;
      4'd9:    img = 8'h6F;
      default: img = 8'h00;
    endcase
    img[7] = dp;
    return img;
  endfunction

  // One step around a ring of n digits.
  function automatic int unsigned ring_next(input int unsigned cur, input int unsigned n);
    return (cur == n - 1) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/segscan_patsel.sv
module segscan_patsel
  import segscan_pkg::*;
(
  input  logic [SEG_W-1:0] bus_byte,
  input  logic             raw_sel,
  output seg_t             pattern
);

  seg_t decoded;

  always_comb begin
    decoded = bcd_to_seg(bus_byte[3:0], bus_byte[SEG_W-1]);
  end

  // Two-input selector: decoded image or the bus byte as-is.
  always_comb begin
    if (raw_sel) pattern = bus_byte;
    else         pattern = decoded;
  end

endmodule

// File: rtl/segscan_regfile.sv
module segscan_regfile
  import segscan_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  seg_t          wdata,
  input  logic [AW-1:0] raddr,
  output seg_t          rdata
);

  seg_t mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/segscan_scanner.sv
module segscan_scanner
  import segscan_pkg::*;
#(
  parameter int DIGITS   = 8,
  parameter int SCAN_DIV = 1024,
  parameter int IW       = $clog2(DIGITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [IW-1:0]     idx,
  output logic              step,
  output logic              blank,
  output logic [DIGITS-1:0] dig_en
);

  localparam int PW = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(SCAN_DIV - 1);

  logic [PW-1:0] pre;

  assign step  = (pre == PRE_LAST);
  assign blank = (pre == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      idx <= '0;
    end else if (step) begin
      pre <= '0;
      idx <= IW'(ring_next(int'(idx), DIGITS));
    end else begin
      pre <= pre + 1'b1;
    end
  end

  // Digit-select decoder fed by the same index as the read port.
  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    assign dig_en[g] = (idx == IW'(g));
  end

endmodule

// File: rtl/segscan_ctrl.sv
module segscan_ctrl
  import segscan_pkg::*;
#(
  parameter int DIGITS   = 8,
  parameter int SCAN_DIV = 1024,
  parameter int AW       = $clog2(DIGITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              raw_mode,
  output logic [7:0]        seg_out,
  output logic [DIGITS-1:0] dig_en
);

  // Internal events brought out for the checker.
  seg_t          wr_pattern;
  seg_t          rd_pattern;
  logic [AW-1:0] scan_idx;
  logic          scan_step;
  logic          seg_blank;

  segscan_patsel u_patsel (
    .bus_byte (wr_data),
    .raw_sel  (raw_mode),
    .pattern  (wr_pattern)
  );

  segscan_regfile #(.DEPTH(DIGITS), .AW(AW)) u_regfile (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_pattern),
    .raddr (scan_idx),
    .rdata (rd_pattern)
  );

  segscan_scanner #(.DIGITS(DIGITS), .SCAN_DIV(SCAN_DIV), .IW(AW)) u_scan (
    .clk    (clk),
    .rst_n  (rst_n),
    .idx    (scan_idx),
    .step   (scan_step),
    .blank  (seg_blank),
    .dig_en (dig_en)
  );

  assign seg_out = seg_blank ? '0 : rd_pattern;

endmodule

// File: rtl/segscan_ctrl_chk.sv
module segscan_ctrl_chk #(
  parameter int DIGITS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              raw_mode,
  input logic [7:0]        wr_data,
  input logic              scan_step,
  input logic              seg_blank,
  input logic [7:0]        wr_pattern,
  input logic [7:0]        seg_out,
  input logic [DIGITS-1:0] dig_en
);

  function automatic logic [DIGITS-1:0] rot1(input logic [DIGITS-1:0] v);
    return {v[DIGITS-2:0], v[DIGITS-1]};
  endfunction

  AST_RESET_VALUES: assert property (@(posedge clk)
    !rst_n |-> (dig_en == DIGITS'(1) && seg_out == '0));  // R1

  AST_ONE_DIGIT_LIT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dig_en) == 1);  // R5

  AST_DIGIT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    scan_step |=> dig_en == rot1($past(dig_en)));  // R5

  AST_DIGIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_step |=> $stable(dig_en));  // R5

  AST_BLANK_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    scan_step |=> seg_out == '0);  // R6

  AST_SEG_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_step && !wr_en && !seg_blank) |=> $stable(seg_out));  // R8

  AST_BCD_OVERRANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !raw_mode && wr_data[3:0] > 4'd9) |-> wr_pattern[6:0] == '0);  // R3

  AST_DP_FOLLOWS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_pattern[7] == wr_data[7]);  // R2

endmodule

bind segscan_ctrl segscan_ctrl_chk #(.DIGITS(DIGITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .raw_mode   (raw_mode),
  .wr_data    (wr_data),
  .scan_step  (scan_step),
  .seg_blank  (seg_blank),
  .wr_pattern (wr_pattern),
  .seg_out    (seg_out),
  .dig_en     (dig_en)
);

// File: tb/segscan_ctrl_test.sv
module segscan_ctrl_test;

  localparam int ND   = 8;
  localparam int DIV  = 4;
  localparam int HALF = 10;  // 50 MHz

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       raw_mode = 1'b0;
  logic [7:0] seg_out;
  logic [7:0] dig_en;

  int total = 0;
  int bad = 0;
  bit done = 0;

  segscan_ctrl #(.DIGITS(ND), .SCAN_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .raw_mode(raw_mode), .seg_out(seg_out), .dig_en(dig_en)
  );

  always #HALF clk = ~clk;

  // Reference state
  int    m_cnt = 0;      // clocks spent in the current slot
  int    m_dig = 0;
  int    m_mem [ND];
  string m_kind [ND];
  string phase = "";
  string strokes [10] = '{"abcdef", "bc", "abdeg", "abcdg", "bcfg",
                          "acdfg", "acdefg", "abc", "abcdefg", "abcdfg"};

  function automatic int expect_pattern(input int b, input bit raw);
    int p = 0;
    if (raw) return b;
    if ((b % 16) < 10) begin
      string s = strokes[b % 16];
      for (int i = 0; i < s.len(); i++) p += 1 << (s[i] - 8'h61);
    end
    if (b >= 128) p += 128;
    return p;
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_outputs();
    string st;
    int es = (m_cnt == 0) ? 0 : m_mem[m_dig];
    if (!rst_n) st = "R1";
    else if (m_cnt == 0) st = "R6";
    else if (phase != "") st = phase;
    else st = m_kind[m_dig];
    check((rst_n && phase == "R7") ? "R7" : (rst_n ? "R5" : "R1"), int'(dig_en), 1 << m_dig);
    check(st, int'(seg_out), es);
  endtask

  // One clock: compare at the falling edge, drive, advance the model.
  task automatic cyc(input bit we, input int a, input int d, input bit raw);
    @(negedge clk);
    compare_outputs();
    wr_en = we; wr_addr = 3'(a); wr_data = 8'(d); raw_mode = raw;
    if (rst_n) begin
      if (we) begin
        m_mem[a] = expect_pattern(d, raw);
        if (raw) m_kind[a] = "R4";
        else if ((d % 16) > 9) m_kind[a] = "R3";
        else m_kind[a] = "R2";
      end
      if (m_cnt == DIV - 1) begin
        m_cnt = 0;
        m_dig = (m_dig + 1) % ND;
      end else m_cnt++;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < ND; i++) begin m_mem[i] = 0; m_kind[i] = "R1"; end
    // R1: outputs while reset is held
    idle(3);
    @(negedge clk);
    compare_outputs();
    rst_n = 1'b1;
    m_cnt = 1;  // the release edge is the first counted clock
    // R1: all entries read back as zero over a full rotation
    phase = "R1";
    idle(ND * DIV + 4);
    phase = "";
    // R2: digits 0..7 with alternating decimal point
    for (int k = 0; k < ND; k++) cyc(1, k, k + ((k % 2) ? 128 : 0), 0);
    idle(ND * DIV + 2);
    cyc(1, 0, 8, 0); cyc(1, 1, 9 + 128, 0); cyc(1, 2, 8'h75, 0);
    idle(ND * DIV + 2);
    // R3: over-range codes, with and without decimal point
    for (int k = 10; k < 16; k++) cyc(1, k - 8, k + ((k > 12) ? 128 : 0), 0);
    idle(ND * DIV + 2);
    // R4: raw segment bytes
    for (int k = 0; k < ND; k++) cyc(1, k, int'($urandom_range(0, 255)), 1);
    cyc(1, 5, 8'hFF, 1); cyc(1, 6, 8'h00, 1); cyc(1, 7, 8'h80, 1);
    idle(ND * DIV + 2);
    // R7: single write leaves other entries intact; bursts keep the scan timing
    phase = "R7";
    cyc(1, 3, 8'h49, 1);
    idle(ND * DIV + 2);
    for (int k = 0; k < 3 * ND * DIV; k++) cyc(1, k % ND, (k * 37) % 256, k[0]);
    idle(ND * DIV + 2);
    // R8: long steady scan after mixed content
    phase = "R8";
    idle(2 * ND * DIV);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(2 * HALF * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule